// File: doc/BRIEF.md
# Steerable Watchdog Timer

This block watches for a stalled processor. Software programs a single 8-bit control byte that holds a timeout multiplier, a resolution select and a steering bit. From the moment of that write, the block counts a slow time-base tick. If software does not write the byte again before the programmed time runs out, the block raises a sticky watchdog flag. It then reacts in one of two ways: it holds a level interrupt request, or it drives an active-low reset pulse of fixed length.

The time base is a one-cycle `tick_en` strobe. `SUB_DIV` ticks make up the smallest resolution step of 1/16 s. With the default of 4, a tick is 1/64 s. The reset pulse lasts `RST_TICKS` ticks; the default of 6 gives about 94 ms. Software clears the flag with a flags-read strobe. The power-down input disables the watchdog. The block also gives two signals to a neighbouring frequency-test function: a priority signal that blocks that function, and a one-cycle pulse that clears its enable bit.

Top module: `wdog_steer`

## Requirements
- R1: A write (`wr_en` with `pwr_down` low) stores `wr_data` in `cfg_q` on the next clock. The fields are: bit 7 = steering (0 interrupt, 1 reset pulse), bits 6:2 = multiplier, bits 1:0 = resolution.
- R2: Resolution codes 00, 01, 10 and 11 select 1, 4, 16 and 64 steps of 1/16 s, where one step is `SUB_DIV` ticks. `wd_flag` rises on the clock of the N-th tick after the write, with N = multiplier × steps × `SUB_DIV`, and not before. For example, 8'h0E gives 3 × 16 × 4 = 192 ticks.
- R3: Any write restarts the countdown from zero, so a periodic rewrite prevents the timeout.
- R4: A multiplier of zero disables the watchdog: no flag, interrupt or pulse is produced, however many ticks arrive.
- R5: With steering 0, a timeout raises `wd_irq`. It stays high through flag reads and through writes of non-zero values, and falls only after a write of 8'h00.
- R6: `wd_flag` stays set until a `flag_rd` strobe clears it. If a timeout and a read happen in the same cycle, the timeout wins.
- R7: With steering 1, a timeout drives `wd_rst_n` low from the next clock for exactly `RST_TICKS` ticks. It does not raise `wd_irq`.
- R8: On the clock that ends the reset pulse, `cfg_q` becomes 8'h00 and `ft_clr` is high for exactly one cycle.
- R9: While `pwr_down` is high, the next clock clears `cfg_q`, stops the countdown and drops `wd_irq`, and writes are ignored.
- R10: `ft_block` is high while `wd_irq` is high, or while `cfg_q` has steering 0 and a non-zero multiplier.
- R11: After reset, `cfg_q` = 8'h00, `wd_irq` = 0, `wd_flag` = 0, `wd_rst_n` = 1, `ft_clr` = 0 and `ft_block` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle time-base strobe (1/(16·SUB_DIV) s) |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte write data |
| flag_rd | input | 1 | Flags-read strobe, clears the watchdog flag |
| pwr_down | input | 1 | Power-down indication |
| wd_irq | output | 1 | Level interrupt request (active high) |
| wd_rst_n | output | 1 | Active-low reset pulse |
| wd_flag | output | 1 | Sticky watchdog flag |
| cfg_q | output | 8 | Current control byte |
| ft_block | output | 1 | Watchdog has priority over the frequency-test function |
| ft_clr | output | 1 | One-cycle pulse that clears the frequency-test enable |

## Verification
The embedded properties check these rules on every cycle:
- the write-to-register path and the interrupt hold/clear rule;
- that the flag follows every expiry;
- that power-down clears the byte;
- that a falling reset pulse always comes from a reset-steered expiry;
- that `ft_clr` coincides with a cleared byte.

Only the directed scenarios can show the following:
- exact timeout lengths for the different resolution codes;
- that a rewrite postpones the timeout;
- that a zero multiplier stays silent over hundreds of ticks;
- the exact reset pulse length;
- that a timeout wins over a flag read in the same cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   typedef struct packed {
      logic       steer;
      logic [4:0] mult;
      logic [1:0] res;
   } wdog_cfg_t;

   // Number of 1/16 s steps selected by a resolution code
   function automatic int unsigned res_steps(input logic [1:0] code);
      case (code)
         2'b00:   return 1;
         2'b01:   return 4;
         2'b10:   return 16;
         default: return 64;
      endcase
   endfunction

endpackage

// File: rtl/wdog_cfg_reg.sv
module wdog_cfg_reg
   import wdog_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_ok,
   input  logic [7:0] wr_data,
   input  logic       pwr_down,
   input  logic       clr,
   input  logic       expire,
   output wdog_cfg_t  cfg,
   output logic       armed
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg   <= '0;
         armed <= 1'b0;
      end else if (pwr_down || clr) begin
         cfg   <= '0;
         armed <= 1'b0;
      end else if (wr_ok) begin
         cfg   <= wdog_cfg_t'(wr_data);
         armed <= (wr_data[6:2] != 5'd0);
      end else if (expire) begin
         armed <= 1'b0;
      end
   end

   // R4: a running countdown always has a non-zero multiplier behind it
   p_armed_mult_r4: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (cfg.mult != 5'd0));

endmodule

// File: rtl/wdog_count.sv
module wdog_count
   import wdog_pkg::*;
#(
   parameter int unsigned SUB_DIV = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic       run,
   input  logic       tick_en,
   input  logic [1:0] res,
   input  logic [4:0] mult,
   output logic       expire
);

   localparam int unsigned MAX_UNIT = SUB_DIV * 64;
   localparam int          PW       = $clog2(MAX_UNIT + 1);

   logic [PW-1:0] pre_cnt;
   logic [PW-1:0] unit_last;
   logic [4:0]    step_cnt;
   logic          unit_wrap;

   always_comb begin
      unit_last = PW'(SUB_DIV * res_steps(res) - 1);
      unit_wrap = run && !restart && tick_en && (pre_cnt == unit_last);
      expire    = unit_wrap && ((step_cnt + 5'd1) == mult);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_cnt  <= '0;
         step_cnt <= '0;
      end else if (restart || !run) begin
         pre_cnt  <= '0;
         step_cnt <= '0;
      end else if (tick_en) begin
         if (pre_cnt == unit_last) begin
            pre_cnt  <= '0;
            step_cnt <= expire ? 5'd0 : step_cnt + 5'd1;
         end else begin
            pre_cnt <= pre_cnt + 1'b1;
         end
      end
   end

   // R2: the step counter never passes the programmed multiplier
   p_step_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (step_cnt < mult));

endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse #(
   parameter int unsigned RST_TICKS = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic tick_en,
   output logic active,
   output logic done
);

   localparam int CW = $clog2(RST_TICKS + 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             active <= 1'b0;
      else if (done)          active <= 1'b0;
      else if (start)         active <= 1'b1;
   end

   generate
      if (RST_TICKS == 1) begin : g_single
         assign done = active && tick_en;
      end else begin : g_multi
         logic [CW-1:0] cnt;
         assign done = active && tick_en && (cnt == CW'(RST_TICKS - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                cnt <= '0;
            else if (!active || done)  cnt <= '0;
            else if (tick_en)          cnt <= cnt + 1'b1;
         end
         // R7: the pulse counter stays inside the programmed length
         p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
            active |-> (cnt < CW'(RST_TICKS)));
      end
   endgenerate

endmodule

// File: rtl/wdog_steer.sv
module wdog_steer
   import wdog_pkg::*;
#(
   parameter int unsigned SUB_DIV   = 4,
   parameter int unsigned RST_TICKS = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_en,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   input  logic       flag_rd,
   input  logic       pwr_down,
   output logic       wd_irq,
   output logic       wd_rst_n,
   output logic       wd_flag,
   output logic [7:0] cfg_q,
   output logic       ft_block,
   output logic       ft_clr
);

   generate
      if (SUB_DIV < 1) begin : g_bad_div
         $error("SUB_DIV must be at least 1");
      end
      if (RST_TICKS < 1) begin : g_bad_pulse
         $error("RST_TICKS must be at least 1");
      end
   endgenerate

   wdog_cfg_t cfg;
   logic      armed;
   logic      wr_ok;
   logic      fire;
   logic      run;
   logic      pulse_active;
   logic      pulse_done;

   assign wr_ok = wr_en && !pwr_down;
   assign run   = armed && !pwr_down;

   wdog_cfg_reg u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ok    (wr_ok),
      .wr_data  (wr_data),
      .pwr_down (pwr_down),
      .clr      (pulse_done),
      .expire   (fire),
      .cfg      (cfg),
      .armed    (armed)
   );

   wdog_count #(.SUB_DIV(SUB_DIV)) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (wr_ok),
      .run     (run),
      .tick_en (tick_en),
      .res     (cfg.res),
      .mult    (cfg.mult),
      .expire  (fire)
   );

   wdog_rst_pulse #(.RST_TICKS(RST_TICKS)) u_pulse (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (fire && cfg.steer),
      .tick_en (tick_en),
      .active  (pulse_active),
      .done    (pulse_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wd_irq  <= 1'b0;
         wd_flag <= 1'b0;
         ft_clr  <= 1'b0;
      end else begin
         ft_clr <= pulse_done;
         if (pwr_down || (wr_ok && wr_data == 8'h00)) wd_irq <= 1'b0;
         else if (fire && !cfg.steer)                 wd_irq <= 1'b1;
         if (fire)         wd_flag <= 1'b1;
         else if (flag_rd) wd_flag <= 1'b0;
      end
   end

   assign cfg_q    = cfg;
   assign wd_rst_n = !pulse_active;
   assign ft_block = wd_irq || (!cfg.steer && cfg.mult != 5'd0);

   // R1: an accepted write lands in the control byte
   p_cfg_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && !pulse_done) |=> (cfg_q == $past(wr_data)));
   // R5: interrupt holds unless cleared by a zero write or power-down
   p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_irq && !pwr_down && !(wr_ok && wr_data == 8'h00)) |=> wd_irq);
   p_irq_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && wr_data == 8'h00) |=> !wd_irq);
   // R6: every expiry leaves the flag set
   p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> wd_flag);
   // R7: the reset pulse only starts from a reset-steered expiry
   p_pulse_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wd_rst_n) |-> $past(fire && cfg.steer));
   // R8: the frequency-test clear coincides with a cleared byte
   p_ftclr_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ft_clr |-> (cfg_q == 8'h00));
   // R9: power-down clears the byte and the interrupt
   p_pwr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down |=> (cfg_q == 8'h00 && !wd_irq));

endmodule

// File: tb/wdog_steer_tb.sv
module wdog_steer_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       flag_rd = 1'b0;
   logic       pwr_down = 1'b0;
   logic       wd_irq, wd_rst_n, wd_flag, ft_block, ft_clr;
   logic [7:0] cfg_q;

   int n_checks = 0;
   int n_fail   = 0;

   always #10 clk = ~clk;

   wdog_steer #(.SUB_DIV(4), .RST_TICKS(6)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .wr_data(wr_data), .flag_rd(flag_rd), .pwr_down(pwr_down),
      .wd_irq(wd_irq), .wd_rst_n(wd_rst_n), .wd_flag(wd_flag),
      .cfg_q(cfg_q), .ft_block(ft_block), .ft_clr(ft_clr)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] d);
      wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         tick_en = 1'b1;
         @(negedge clk);
         tick_en = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic rd_flags();
      flag_rd = 1'b1;
      @(negedge clk);
      flag_rd = 1'b0;
   endtask

   task automatic t_reset();
      check("R11 cfg", cfg_q, 8'h00);
      check("R11 irq", wd_irq, 0);
      check("R11 flag", wd_flag, 0);
      check("R11 rst_n", wd_rst_n, 1);
      check("R11 ft_clr", ft_clr, 0);
      check("R11 ft_block", ft_block, 0);
   endtask

   task automatic t_irq_path();
      wr(8'h0E);
      check("R1 cfg write", cfg_q, 8'h0E);
      check("R10 ft_block armed", ft_block, 1);
      tick(191);
      check("R2 no early flag", wd_flag, 0);
      check("R5 no early irq", wd_irq, 0);
      tick(1);
      check("R2 flag at 192", wd_flag, 1);
      check("R5 irq set", wd_irq, 1);
      check("R7 no pulse on irq steer", wd_rst_n, 1);
      rd_flags();
      check("R6 read clears flag", wd_flag, 0);
      check("R5 irq survives read", wd_irq, 1);
      wr(8'h80);
      check("R5 irq survives nonzero write", wd_irq, 1);
      check("R10 ft_block by irq", ft_block, 1);
      wr(8'h00);
      check("R5 zero write clears irq", wd_irq, 0);
      check("R10 ft_block idle", ft_block, 0);
   endtask

   task automatic t_kick();
      wr(8'h04);
      tick(3);
      wr(8'h04);
      tick(3);
      check("R3 rewrite postpones", wd_flag, 0);
      tick(1);
      check("R3 timeout after kick", wd_flag, 1);
      wr(8'h00);
      rd_flags();
   endtask

   task automatic t_res01();
      wr(8'h09);            // mult 2, res 01: 2*4*4 = 32 ticks
      tick(31);
      check("R2 res01 early", wd_flag, 0);
      tick(1);
      check("R2 res01 flag", wd_flag, 1);
      wr(8'h00);
      rd_flags();
   endtask

   task automatic t_set_wins();
      wr(8'h04);
      tick(3);
      tick_en = 1'b1; flag_rd = 1'b1;
      @(negedge clk);
      tick_en = 1'b0; flag_rd = 1'b0;
      check("R6 set wins over read", wd_flag, 1);
      wr(8'h00);
      rd_flags();
   endtask

   task automatic t_zero_mult();
      wr(8'h03);
      tick(300);
      check("R4 zero mult flag", wd_flag, 0);
      check("R4 zero mult irq", wd_irq, 0);
      check("R4 zero mult pulse", wd_rst_n, 1);
      check("R10 zero mult no block", ft_block, 0);
   endtask

   task automatic t_reset_path();
      wr(8'h84);
      check("R10 reset steer no block", ft_block, 0);
      tick(4);
      check("R7 pulse starts", wd_rst_n, 0);
      check("R7 flag set", wd_flag, 1);
      check("R7 no irq", wd_irq, 0);
      tick(5);
      check("R7 pulse still low", wd_rst_n, 0);
      check("R8 cfg held in pulse", cfg_q, 8'h84);
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
      check("R7 pulse ends", wd_rst_n, 1);
      check("R8 cfg cleared", cfg_q, 8'h00);
      check("R8 ft_clr high", ft_clr, 1);
      @(negedge clk);
      check("R8 ft_clr one cycle", ft_clr, 0);
      rd_flags();
   endtask

   task automatic t_pwr();
      wr(8'h0C);
      tick(5);
      pwr_down = 1'b1;
      @(negedge clk);
      check("R9 cfg cleared", cfg_q, 8'h00);
      wr(8'h55);
      check("R9 write ignored", cfg_q, 8'h00);
      pwr_down = 1'b0;
      tick(50);
      check("R9 count stopped", wd_flag, 0);
      wr(8'h04);
      tick(4);
      check("R9 irq set again", wd_irq, 1);
      pwr_down = 1'b1;
      @(negedge clk);
      pwr_down = 1'b0;
      check("R9 irq dropped", wd_irq, 0);
      rd_flags();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_irq_path();
      t_kick();
      t_res01();
      t_set_wins();
      t_zero_mult();
      t_reset_path();
      t_pwr();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule